// File: doc/BRIEF.md
# Debounced Floor Position Tracker

This block follows the car of a lift through a shaft fitted with five infrared beam-break sensors, one per landing. Each raw sensor line is filtered by its own three-stage shift register. That register is clocked only on a slow sampling tick, which is taken from a free-running counter. A filtered line changes only once all three stages agree.

The filtered vector, together with the motor's direction and running flag, drives a floor register. Between sensors every filtered line reads zero, and the register keeps its last value. When two neighbouring sensors are cut at once, the floor is chosen by testing single bits, with the travel direction deciding which bit wins.

The outputs are a 3-bit binary floor index and a one-clock strobe that fires when the car reaches a new floor while the motor is running.

Top module: `floor_tracker`

## Requirements
- R1: Sensor bit i stands for floor i. A raw level reads 1 when the beam is cut. It reaches the floor logic only after three consecutive sampling ticks have captured the same level, so a change that covers fewer than three ticks has no effect on `floor_idx`.
- R2: The sampling tick fires once every 2^(TICK_BIT+1) clocks, on the rising edge of bit TICK_BIT of a free-running CNT_W-bit counter. The debounce stages shift only on that tick.
- R3: While all five filtered lines are 0 (the car is between sensors), `floor_idx` keeps its previous value and `arrive_pulse` stays 0.
- R4: When `motor_run`=1 and `motor_dir`=0 (moving up), the floor becomes the highest set filtered bit. For example, filtered 00110 gives floor 2.
- R5: When `motor_run`=1 and `motor_dir`=1 (moving down), the floor becomes the lowest set filtered bit. For example, filtered 00110 gives floor 1.
- R6: When `motor_run`=0, the floor is held if the filtered bit at the current floor is set. Otherwise the floor becomes the lowest set filtered bit.
- R7: `arrive_pulse` is high for exactly one clock, in the cycle in which `floor_idx` first shows a new value that was taken while `motor_run`=1. It stays 0 for floor changes taken while `motor_run`=0.
- R8: A synchronous active-high `rst` sets `floor_idx` to 0 and `arrive_pulse` to 0, and clears every debounce stage and the sampling counter.
- R9: `floor_idx` is always below 5. Whenever it changes, it names a filtered bit that was set in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sensor_raw | input | 5 | Raw beam-break lines, bit i = floor i, 1 = beam cut |
| motor_dir | input | 1 | Travel direction, 0 = up, 1 = down |
| motor_run | input | 1 | 1 = motor running, 0 = idle |
| floor_idx | output | 3 | Current floor, binary 0 to 4 |
| arrive_pulse | output | 1 | One-clock strobe on a new floor taken while running |

## Verification
The bench targets these corner cases:
- Blind spots between two landings. A tracker that decodes only exact one-hot patterns would drop to a default floor there.
- Pairs of neighbouring sensors cut at once, in both directions. A design that ignores direction would report the wrong landing on one of the two passes.
- Sensor glitches that span one or two sampling ticks. A filter that follows a single sample would make the floor jump, and a filter that ignores the tick would do the same.
- Reset while a sensor is steadily cut. Stale filter stages would move the floor straight after reset.
- Floor changes while the motor is idle. A strobe that is not gated by the running flag would fire falsely.

// File: rtl/floor_trk_pkg.sv
package floor_trk_pkg;

    typedef enum logic [1:0] {
        MOV_IDLE = 2'd0,
        MOV_UP   = 2'd1,
        MOV_DOWN = 2'd2
    } motion_e;

    localparam logic DIR_DOWN = 1'b1;

    function automatic motion_e to_motion(input logic run, input logic dir);
        if (!run)
            return MOV_IDLE;
        else if (dir == DIR_DOWN)
            return MOV_DOWN;
        else
            return MOV_UP;
    endfunction

endpackage

// File: rtl/flr_tick_gen.sv
module flr_tick_gen #(
    parameter int CNT_W    = 24,
    parameter int TICK_BIT = 19
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [CNT_W-1:0] cnt_q;
    logic             prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            prev_q <= cnt_q[TICK_BIT];
        end
    end

    assign tick = cnt_q[TICK_BIT] & ~prev_q;
endmodule

// File: rtl/flr_debounce.sv
module flr_debounce #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic raw,
    output logic clean
);
    logic [DEPTH-1:0] sh_q;
    logic             clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            clean_q <= 1'b0;
        end else begin
            if (sample_en)
                sh_q <= {sh_q[DEPTH-2:0], raw};
            if (&sh_q)
                clean_q <= 1'b1;
            else if (~|sh_q)
                clean_q <= 1'b0;
        end
    end

    assign clean = clean_q;
endmodule

// File: rtl/flr_floor_reg.sv
module flr_floor_reg
    import floor_trk_pkg::*;
#(
    parameter int N  = 5,
    parameter int FW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  deb,
    input  motion_e       motion,
    output logic [FW-1:0] floor_idx,
    output logic          arrive
);
    logic [FW-1:0] floor_q, floor_d, hi_idx, lo_idx;
    logic          any_set, cur_hit, arrive_q;

    // Highest and lowest set bits, each found by testing single bits
    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < N; i++)
            if (deb[i]) hi_idx = FW'(i);
        lo_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (deb[i]) lo_idx = FW'(i);
        cur_hit = 1'b0;
        for (int i = 0; i < N; i++)
            if (deb[i] && (FW'(i) == floor_q)) cur_hit = 1'b1;
        any_set = |deb;
    end

    always_comb begin
        floor_d = floor_q;
        if (any_set) begin
            unique case (motion)
                MOV_UP:   floor_d = hi_idx;
                MOV_DOWN: floor_d = lo_idx;
                default:  floor_d = cur_hit ? floor_q : lo_idx;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            floor_q  <= '0;
            arrive_q <= 1'b0;
        end else begin
            floor_q  <= floor_d;
            arrive_q <= (motion != MOV_IDLE) && (floor_d != floor_q);
        end
    end

    assign floor_idx = floor_q;
    assign arrive    = arrive_q;
endmodule

// File: rtl/floor_tracker.sv
module floor_tracker
    import floor_trk_pkg::*;
#(
    parameter int NUM_SENSORS = 5,
    parameter int CNT_W       = 24,
    parameter int TICK_BIT    = 19,
    parameter int DEB_DEPTH   = 3,
    localparam int FLOOR_W    = $clog2(NUM_SENSORS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [4:0]         sensor_raw,
    input  logic               motor_dir,
    input  logic               motor_run,
    output logic [FLOOR_W-1:0] floor_idx,
    output logic               arrive_pulse
);
    logic                   tick;
    logic [NUM_SENSORS-1:0] deb_vec;
    motion_e                motion;

    flr_tick_gen #(.CNT_W(CNT_W), .TICK_BIT(TICK_BIT)) tick_i (
        .clk(clk), .rst(rst), .tick(tick)
    );

    for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_deb
        flr_debounce #(.DEPTH(DEB_DEPTH)) deb_i (
            .clk(clk), .rst(rst), .sample_en(tick),
            .raw(sensor_raw[g]), .clean(deb_vec[g])
        );
    end

    assign motion = to_motion(motor_run, motor_dir);

    flr_floor_reg #(.N(NUM_SENSORS), .FW(FLOOR_W)) floor_i (
        .clk(clk), .rst(rst), .deb(deb_vec), .motion(motion),
        .floor_idx(floor_idx), .arrive(arrive_pulse)
    );
endmodule

// File: rtl/floor_tracker_chk.sv
module floor_tracker_chk #(
    parameter int N  = 5,
    parameter int FW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          motor_run,
    input logic [N-1:0]  deb,
    input logic [FW-1:0] floor_idx,
    input logic          arrive_pulse
);
    logic [N-1:0] deb_d;
    logic         sel_hit;

    always_ff @(posedge clk) deb_d <= deb;
    assign sel_hit = |(deb_d & (N'(1) << floor_idx));

    // R8
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (floor_idx == '0) && !arrive_pulse);

    // R3
    blind_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (deb == '0) |=> (floor_idx == $past(floor_idx)) && !arrive_pulse);

    // R7
    arrive_cause_chk: assert property (@(posedge clk) disable iff (rst)
        arrive_pulse |-> $past(motor_run) && (floor_idx != $past(floor_idx)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !motor_run |=> !arrive_pulse);

    // R9
    floor_range_chk: assert property (@(posedge clk) disable iff (rst)
        floor_idx < FW'(N));

    // R9
    floor_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(floor_idx) |-> sel_hit);
endmodule

bind floor_tracker floor_tracker_chk #(.N(NUM_SENSORS), .FW(FLOOR_W)) chk_i (
    .clk(clk), .rst(rst), .motor_run(motor_run), .deb(deb_vec),
    .floor_idx(floor_idx), .arrive_pulse(arrive_pulse)
);

// File: tb/floor_tracker_tb_top.sv
`timescale 1ns/1ps
module floor_tracker_tb_top;
    localparam int TB_TICK_BIT = 2;   // tick every 8 clocks
    localparam int HOLD = 40;         // five ticks, enough to debounce

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] sensor_raw = '0;
    logic       motor_dir = 1'b0;
    logic       motor_run = 1'b0;
    logic [2:0] floor_idx;
    logic       arrive_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    int arr_cnt = 0;

    always #2.5 clk = ~clk;

    floor_tracker #(.TICK_BIT(TB_TICK_BIT)) dut_i (
        .clk(clk), .rst(rst), .sensor_raw(sensor_raw),
        .motor_dir(motor_dir), .motor_run(motor_run),
        .floor_idx(floor_idx), .arrive_pulse(arrive_pulse)
    );

    always @(posedge clk) if (!rst && arrive_pulse) arr_cnt <= arr_cnt + 1;

    // {sensors, run, dir, expected floor, expected arrivals}
    localparam logic [11:0] STEPS [0:12] = '{
        {5'b00001, 1'b1, 1'b0, 3'd0, 2'd0},  // R4 already there
        {5'b00000, 1'b1, 1'b0, 3'd0, 2'd0},  // R3 blind spot
        {5'b00011, 1'b1, 1'b0, 3'd1, 2'd1},  // R4 pair, up -> higher
        {5'b00010, 1'b1, 1'b0, 3'd1, 2'd0},  // R4 stays
        {5'b00000, 1'b1, 1'b0, 3'd1, 2'd0},  // R3 blind spot
        {5'b00110, 1'b1, 1'b0, 3'd2, 2'd1},  // R4 pair, up -> higher
        {5'b00100, 1'b0, 1'b0, 3'd2, 2'd0},  // R6 idle, hold
        {5'b01100, 1'b0, 1'b0, 3'd2, 2'd0},  // R6 current bit set, hold
        {5'b11000, 1'b1, 1'b1, 3'd3, 2'd1},  // R5 pair, down -> lower
        {5'b00000, 1'b1, 1'b1, 3'd3, 2'd0},  // R3 blind spot
        {5'b00110, 1'b1, 1'b1, 3'd1, 2'd1},  // R5 pair, down -> lower
        {5'b10000, 1'b0, 1'b1, 3'd4, 2'd0},  // R6 idle move, R7 no strobe
        {5'b00001, 1'b1, 1'b1, 3'd0, 2'd1}   // R5 and R7
    };

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check("R8 reset floor", int'(floor_idx), 0);
        check("R8 reset strobe", int'(arrive_pulse), 0);
        rst = 1'b0;

        foreach (STEPS[k]) begin
            sensor_raw = STEPS[k][11:7];
            motor_run  = STEPS[k][6];
            motor_dir  = STEPS[k][5];
            base = arr_cnt;
            repeat (HOLD) @(negedge clk);
            check($sformatf("R3-6 step %0d floor", k), int'(floor_idx), int'(STEPS[k][4:2]));
            check($sformatf("R7 step %0d arrivals", k), arr_cnt - base, int'(STEPS[k][1:0]));
        end

        // R1 R2: glitch covering two ticks is filtered (floor 0, running up)
        motor_run = 1'b1; motor_dir = 1'b0;
        base = arr_cnt;
        sensor_raw = 5'b00100;
        repeat (16) @(negedge clk);
        sensor_raw = 5'b00001;
        repeat (HOLD) @(negedge clk);
        check("R1 glitch floor", int'(floor_idx), 0);
        check("R1 glitch arrivals", arr_cnt - base, 0);

        // R6: idle, current bit clear -> lowest set bit; R7 no strobe
        motor_run = 1'b0;
        sensor_raw = 5'b00100;
        base = arr_cnt;
        repeat (HOLD) @(negedge clk);
        check("R6 idle relocate", int'(floor_idx), 2);
        check("R7 idle no strobe", arr_cnt - base, 0);

        // R8: reset with a sensor steadily cut
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 mid reset floor", int'(floor_idx), 0);
        check("R8 mid reset strobe", int'(arrive_pulse), 0);
        rst = 1'b0;
        repeat (16) @(negedge clk);
        check("R8 stages cleared", int'(floor_idx), 0);
        repeat (HOLD) @(negedge clk);
        check("R2 settles after three ticks", int'(floor_idx), 2);

        summary();
        $finish;
    end
endmodule